// File: doc/BRIEF.md
# DMA Descriptor Loader

This block prepares a DMA channel to move data. It runs when the channel is started or when a work unit ends. At that point the channel's register values are presented on the input ports and a one-cycle `start` is given. The block takes a copy of those values. It then decodes the transfer mode and the descriptor length from the configuration word that was presented with `start`. Next it fetches zero to nine 16-bit descriptor words over a simple request/response read port and writes each word into a parameter register. Last, it derives the working state: the current descriptor pointer, the current address, the current X and Y counts, and the element size. It also checks that the start address is aligned to the element size.

There are five transfer modes, and each one fixes three things: whether any words are read, how many words are allowed, and which pointer the reads start from. The two linked-list modes first reload the next-descriptor pointer and only then fill the other parameters. A mode code or descriptor length that is not allowed is not fetched. It stops the channel and raises the error flag. The data engine waits for the `done` pulse before it moves any data.

The controller has five states. `IDLE` waits for `start`. `DECODE` checks the mode and the length. `FETCH` reads and stores the descriptor words. `APPLY` derives the working state. `DONE` raises `done` for one cycle. The transitions are:
- *launch*: `IDLE` to `DECODE` on `start`.
- *reject*: `DECODE` to `IDLE` on an illegal mode or length.
- *skip*: `DECODE` to `APPLY` when zero words are needed.
- *fetch*: `DECODE` to `FETCH` when one or more words are needed.
- *last word*: `FETCH` to `APPLY` when the final response arrives.
- *settle*: `APPLY` to `DONE`.
- *release*: `DONE` to `IDLE`.

Top module: `dma_desc_loader`

## Requirements
- R1: The mode field is `cfg_in[14:12]`. Code 0 (stop) and code 1 (autobuffer) are legal only when the length field `cfg_in[11:8]` is 0. Both codes then issue no reads and still end with `done`.
- R2: Mode code 4 (array) accepts a length of 1 to 7. It reads that many words from `cur_ptr_in`, `cur_ptr_in+2`, and so on.
- R3: Mode code 6 (small list) accepts a length of 1 to 8. It reads from `next_ptr_in` upward. The first word replaces bits 15:0 of the next-descriptor pointer, and bits 31:16 keep their value.
- R4: Mode code 7 (large list) accepts a length of 1 to 9. It reads from `next_ptr_in` upward. The first word replaces bits 15:0 of the next-descriptor pointer and the second word replaces bits 31:16.
- R5: The words left after the pointer words go, in this order, to: start address bits 15:0, start address bits 31:16, config, X count, X modify, Y count, Y modify. A register that receives no word keeps the value presented at `start`.
- R6: Mode codes 2, 3 and 5 are illegal, and so is any length outside the range for its mode. Either one sets `err`, clears `run`, issues no read and gives no `done`.
- R7: After loading, `cur_ptr` equals the final next-descriptor pointer and `cur_addr` equals the final start address.
- R8: A final X count or Y count of zero is loaded into `cur_x` or `cur_y` as 0xFFFF. Any other value is copied unchanged.
- R9: `elem_bytes` is taken from bits 3:2 of the final config word. The value 2 gives 4 bytes, the value 1 gives 2 bytes, and any other value gives 1 byte.
- R10: If the final start address is not a multiple of `elem_bytes`, `err` is set. `done` still pulses and `run` stays high.
- R11: `start` is accepted only in `IDLE`. It clears `err` and sets `run`. `busy` stays high until the block returns to `IDLE`, and `done` is high for exactly one cycle.
- R12: While `rd_req` is high and no `rd_valid` has arrived, `rd_req` stays high and `rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to load the channel |
| cfg_in | input | 16 | Configuration word presented at start |
| next_ptr_in | input | 32 | Next-descriptor pointer presented at start |
| cur_ptr_in | input | 32 | Current descriptor pointer presented at start |
| start_in | input | 32 | Start address presented at start |
| xcnt_in | input | 16 | X count presented at start |
| xmod_in | input | 16 | X modify presented at start |
| ycnt_in | input | 16 | Y count presented at start |
| ymod_in | input | 16 | Y modify presented at start |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 16 | Read response word |
| busy | output | 1 | High while the block is not in `IDLE` |
| done | output | 1 | One-cycle pulse when the load is complete |
| run | output | 1 | Channel running flag |
| err | output | 1 | Error flag |
| elem_bytes | output | 3 | Element size in bytes |
| next_ptr | output | 32 | Next-descriptor pointer |
| start_addr | output | 32 | Start address |
| cfg | output | 16 | Config word |
| xcnt | output | 16 | X count |
| xmod | output | 16 | X modify |
| ycnt | output | 16 | Y count |
| ymod | output | 16 | Y modify |
| cur_ptr | output | 32 | Current descriptor pointer |
| cur_addr | output | 32 | Current address |
| cur_x | output | 16 | Current X count |
| cur_y | output | 16 | Current Y count |

## Verification
Some rules are checked by the assertions on every cycle:
- the read request stays asserted with a stable address until its response arrives;
- `done` lasts a single cycle;
- a rejected mode is followed by a stopped channel with `err` set;
- no completed load shows a zero current count;
- a misaligned start address always sets `err`.

Other behaviour can be shown only by the bench's sweep, which covers every mode code with every length. That sweep covers which pointer the reads start from, how many reads are made, which word lands in which register, and the derived element size and current values. It uses a memory holding computed contents and a response port that stalls on some cycles.

// File: rtl/dld_pkg.sv
package dld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_FETCH,
        ST_APPLY,
        ST_DONE
    } ld_state_e;

    // transfer mode codes (config bits 14:12)
    localparam logic [2:0] FL_STOP  = 3'd0;
    localparam logic [2:0] FL_AUTO  = 3'd1;
    localparam logic [2:0] FL_ARRAY = 3'd4;
    localparam logic [2:0] FL_SMALL = 3'd6;
    localparam logic [2:0] FL_LARGE = 3'd7;

    // parameter slot order; the loader's word mapping depends on it
    localparam int NSLOT     = 9;
    localparam int SL_NDP_LO = 0;
    localparam int SL_NDP_HI = 1;
    localparam int SL_SA_LO  = 2;
    localparam int SL_SA_HI  = 3;
    localparam int SL_CFG    = 4;
    localparam int SL_XCNT   = 5;
    localparam int SL_XMOD   = 6;
    localparam int SL_YCNT   = 7;
    localparam int SL_YMOD   = 8;

endpackage

// File: rtl/dld_decode.sv
module dld_decode
    import dld_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [2:0]    flow,
    input  logic [CW-1:0] nsize,
    input  logic [CW-1:0] widx,
    output logic          legal,
    output logic          from_cur,
    output logic [CW-1:0] slot
);

    always_comb begin
        legal    = 1'b0;
        from_cur = 1'b0;
        slot     = '0;
        case (flow)
            FL_STOP, FL_AUTO: begin
                legal = (nsize == '0);
            end
            FL_ARRAY: begin
                legal    = (nsize != '0) && (nsize <= CW'(7));
                from_cur = 1'b1;
                slot     = widx + CW'(SL_SA_LO);
            end
            FL_SMALL: begin
                legal = (nsize != '0) && (nsize <= CW'(8));
                slot  = (widx == '0) ? CW'(SL_NDP_LO) : widx + CW'(1);
            end
            FL_LARGE: begin
                legal = (nsize != '0) && (nsize <= CW'(9));
                slot  = widx;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dld_regfile.sv
module dld_regfile
    import dld_pkg::*;
#(
    parameter int WW = 16,
    parameter int CW = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [NSLOT-1:0][WW-1:0]   init_vals,
    input  logic                       wr_en,
    input  logic [CW-1:0]              wr_slot,
    input  logic [WW-1:0]              wr_data,
    output logic [NSLOT-1:0][WW-1:0]   slots
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[i] <= '0;
            end else if (load_en) begin
                slots[i] <= init_vals[i];
            end else if (wr_en && (wr_slot == CW'(i))) begin
                slots[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dld_fsm.sv
module dld_fsm
    import dld_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          legal,
    input  logic [CW-1:0] nwords,
    input  logic          from_cur,
    input  logic [AW-1:0] cur_base,
    input  logic [AW-1:0] next_base,
    input  logic          rd_valid,
    output logic [CW-1:0] widx,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic          load_en,
    output logic          apply_en,
    output logic          fault,
    output logic          done,
    output logic          busy
);

    ld_state_e st_q, st_d;
    logic [AW-1:0] addr_q;
    logic          last_word;

    assign last_word = (widx == nwords - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = ST_DECODE;
            ST_DECODE: begin
                if (!legal)              st_d = ST_IDLE;
                else if (nwords == '0)   st_d = ST_APPLY;
                else                     st_d = ST_FETCH;
            end
            ST_FETCH:  if (rd_valid && last_word) st_d = ST_APPLY;
            ST_APPLY:  st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req   = 1'b0;
        wr_en    = 1'b0;
        load_en  = 1'b0;
        apply_en = 1'b0;
        fault    = 1'b0;
        done     = 1'b0;
        busy     = (st_q != ST_IDLE);
        unique case (st_q)
            ST_IDLE:   load_en  = start;
            ST_DECODE: fault    = !legal;
            ST_FETCH: begin
                rd_req = 1'b1;
                wr_en  = rd_valid;
            end
            ST_APPLY:  apply_en = 1'b1;
            ST_DONE:   done     = 1'b1;
            default:   busy     = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx   <= '0;
            addr_q <= '0;
        end else if (st_q == ST_DECODE) begin
            widx   <= '0;
            addr_q <= from_cur ? cur_base : next_base;
        end else if (st_q == ST_FETCH && rd_valid) begin
            widx   <= widx + CW'(1);
            addr_q <= addr_q + AW'(2);
        end
    end

    assign rd_addr = addr_q;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (widx < nwords));

endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
    import dld_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   cfg_in,
    input  logic [31:0]   next_ptr_in,
    input  logic [31:0]   cur_ptr_in,
    input  logic [31:0]   start_in,
    input  logic [15:0]   xcnt_in,
    input  logic [15:0]   xmod_in,
    input  logic [15:0]   ycnt_in,
    input  logic [15:0]   ymod_in,
    output logic          rd_req,
    output logic [31:0]   rd_addr,
    input  logic          rd_valid,
    input  logic [15:0]   rd_data,
    output logic          busy,
    output logic          done,
    output logic          run,
    output logic          err,
    output logic [2:0]    elem_bytes,
    output logic [31:0]   next_ptr,
    output logic [31:0]   start_addr,
    output logic [15:0]   cfg,
    output logic [15:0]   xcnt,
    output logic [15:0]   xmod,
    output logic [15:0]   ycnt,
    output logic [15:0]   ymod,
    output logic [31:0]   cur_ptr,
    output logic [31:0]   cur_addr,
    output logic [15:0]   cur_x,
    output logic [15:0]   cur_y
);

    localparam int AW = 2 * WW;
    localparam int CW = 4;

    logic [NSLOT-1:0][WW-1:0] init_vals, slots;
    logic [2:0]    flow_q;
    logic [CW-1:0] nsize_q, widx, slot;
    logic          legal, from_cur, wr_en, load_en, apply_en, fault;
    logic [2:0]    elem_d;
    logic          misal;
    logic [AW-1:0] ndp, sa;

    assign init_vals[SL_NDP_LO] = next_ptr_in[WW-1:0];
    assign init_vals[SL_NDP_HI] = next_ptr_in[AW-1:WW];
    assign init_vals[SL_SA_LO]  = start_in[WW-1:0];
    assign init_vals[SL_SA_HI]  = start_in[AW-1:WW];
    assign init_vals[SL_CFG]    = cfg_in;
    assign init_vals[SL_XCNT]   = xcnt_in;
    assign init_vals[SL_XMOD]   = xmod_in;
    assign init_vals[SL_YCNT]   = ycnt_in;
    assign init_vals[SL_YMOD]   = ymod_in;

    dld_decode #(.CW(CW)) u_dec (
        .flow     (flow_q),
        .nsize    (nsize_q),
        .widx     (widx),
        .legal    (legal),
        .from_cur (from_cur),
        .slot     (slot)
    );

    dld_fsm #(.AW(AW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .legal     (legal),
        .nwords    (nsize_q),
        .from_cur  (from_cur),
        .cur_base  (cur_ptr),
        .next_base (ndp),
        .rd_valid  (rd_valid),
        .widx      (widx),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .load_en   (load_en),
        .apply_en  (apply_en),
        .fault     (fault),
        .done      (done),
        .busy      (busy)
    );

    dld_regfile #(.WW(WW), .CW(CW)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .init_vals (init_vals),
        .wr_en     (wr_en),
        .wr_slot   (slot),
        .wr_data   (rd_data),
        .slots     (slots)
    );

    assign ndp        = {slots[SL_NDP_HI], slots[SL_NDP_LO]};
    assign sa         = {slots[SL_SA_HI], slots[SL_SA_LO]};
    assign next_ptr   = ndp;
    assign start_addr = sa;
    assign cfg        = slots[SL_CFG];
    assign xcnt       = slots[SL_XCNT];
    assign xmod       = slots[SL_XMOD];
    assign ycnt       = slots[SL_YCNT];
    assign ymod       = slots[SL_YMOD];

    always_comb begin
        unique case (cfg[3:2])
            2'b10:   elem_d = 3'd4;
            2'b01:   elem_d = 3'd2;
            default: elem_d = 3'd1;
        endcase
        misal = |(sa[1:0] & (elem_d[1:0] - 2'd1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q     <= '0;
            nsize_q    <= '0;
            run        <= 1'b0;
            err        <= 1'b0;
            elem_bytes <= 3'd1;
            cur_ptr    <= '0;
            cur_addr   <= '0;
            cur_x      <= '0;
            cur_y      <= '0;
        end else if (load_en) begin
            flow_q  <= cfg_in[14:12];
            nsize_q <= cfg_in[11:8];
            run     <= 1'b1;
            err     <= 1'b0;
            cur_ptr <= cur_ptr_in;
        end else if (fault) begin
            run <= 1'b0;
            err <= 1'b1;
        end else if (apply_en) begin
            cur_ptr    <= ndp;
            cur_addr   <= sa;
            cur_x      <= (xcnt == '0) ? '1 : xcnt;
            cur_y      <= (ycnt == '0) ? '1 : ycnt;
            elem_bytes <= elem_d;
            if (misal) err <= 1'b1;
        end
    end

    // R6
    reject_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!run && err && !rd_req));

    // R8
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_x != '0 && cur_y != '0));

    // R10
    align_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((cur_addr[1:0] & (elem_bytes[1:0] - 2'd1)) != 2'd0)) |-> (err && run));

    // R7
    cur_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cur_addr == start_addr && cur_ptr == next_ptr));

endmodule

// File: tb/sim_dma_desc_loader.sv
`timescale 1ns/100ps
module sim_dma_desc_loader;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cfg_in = '0, xcnt_in = '0, xmod_in = '0, ycnt_in = '0, ymod_in = '0;
    logic [31:0] next_ptr_in = '0, cur_ptr_in = '0, start_in = '0;
    logic rd_req, rd_valid = 1'b0;
    logic [31:0] rd_addr;
    logic [15:0] rd_data = '0;
    logic busy, done, run, err;
    logic [2:0] elem_bytes;
    logic [31:0] next_ptr, start_addr, cur_ptr, cur_addr;
    logic [15:0] cfg, xcnt, xmod, ycnt, ymod, cur_x, cur_y;

    int total = 0;
    int bad = 0;
    int nreads = 0;
    int tick = 0;

    always #2.5 clk = ~clk;

    dma_desc_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .next_ptr_in(next_ptr_in), .cur_ptr_in(cur_ptr_in), .start_in(start_in),
        .xcnt_in(xcnt_in), .xmod_in(xmod_in), .ycnt_in(ycnt_in), .ymod_in(ymod_in),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .run(run), .err(err), .elem_bytes(elem_bytes),
        .next_ptr(next_ptr), .start_addr(start_addr), .cfg(cfg), .xcnt(xcnt),
        .xmod(xmod), .ycnt(ycnt), .ymod(ymod), .cur_ptr(cur_ptr),
        .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y)
    );

    function automatic logic [15:0] memw(logic [31:0] a);
        if (a[5:1] == 5'd9) return 16'h0000;
        return (a[15:0] * 16'h9E37) ^ 16'h1234;
    endfunction

    // memory: responds at negedge, stalls every third cycle
    always @(negedge clk) begin
        tick++;
        if (rd_valid) nreads++;
        rd_valid = rd_req && (tick % 3 != 0);
        rd_data  = memw(rd_addr);
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_case(int fl, int ns, int ws, logic [31:0] nxt, logic [31:0] cur,
                            logic [31:0] sa, logic [15:0] xc, logic [15:0] yc);
        logic [15:0] e [9];
        logic legal;
        int slot;
        int dcnt;
        logic [2:0] eb;
        logic misal;
        logic [31:0] src;
        logic [15:0] cf;
        cf = {1'b0, 3'(fl), 4'(ns), 4'b0, 2'(ws), 2'b0};
        e[0] = nxt[15:0]; e[1] = nxt[31:16]; e[2] = sa[15:0]; e[3] = sa[31:16];
        e[4] = cf; e[5] = xc; e[6] = 16'h0004; e[7] = yc; e[8] = 16'hFFF0;
        case (fl)
            0, 1:    legal = (ns == 0);
            4:       legal = (ns >= 1 && ns <= 7);
            6:       legal = (ns >= 1 && ns <= 8);
            7:       legal = (ns >= 1 && ns <= 9);
            default: legal = 1'b0;
        endcase
        src = (fl == 4) ? cur : nxt;
        if (legal) begin
            for (int k = 0; k < ns; k++) begin
                if (fl == 4)      slot = k + 2;
                else if (fl == 6) slot = (k == 0) ? 0 : k + 1;
                else              slot = k;
                e[slot] = memw(src + 32'(2 * k));
            end
        end
        case (e[4][3:2])
            2'b10:   eb = 3'd4;
            2'b01:   eb = 3'd2;
            default: eb = 3'd1;
        endcase
        misal = ({e[3], e[2]} % {29'd0, eb}) != 0;

        @(negedge clk);
        cfg_in = cf; next_ptr_in = nxt; cur_ptr_in = cur; start_in = sa;
        xcnt_in = xc; xmod_in = 16'h0004; ycnt_in = yc; ymod_in = 16'hFFF0;
        start = 1'b1;
        nreads = 0;
        @(negedge clk);
        start = 1'b0;
        dcnt = 0;
        for (int c = 0; c < 300; c++) begin
            if (done) dcnt++;
            if (!busy) break;
            @(negedge clk);
        end
        if (busy) chk("R11 load never finished", 1, 0);

        chk("R11 done pulse count", dcnt, legal ? 1 : 0);
        chk("R6 reads issued", nreads, legal ? ns : 0);
        if (fl <= 1) chk("R1 no fetch in stop/autobuffer", nreads, 0);
        if (!legal) begin
            chk("R6 run cleared", run, 0);
            chk("R6 err set", err, 1);
            chk("R6 params untouched", {xcnt, ycnt}, {xc, yc});
        end else begin
            if (fl == 4) chk("R2 array loaded start addr", start_addr, {e[3], e[2]});
            if (fl == 6) chk("R3 small ptr halves", next_ptr, {nxt[31:16], e[0]});
            if (fl == 7) chk("R4 large ptr halves", next_ptr, {e[1], e[0]});
            chk("R5 start addr", start_addr, {e[3], e[2]});
            chk("R5 config", cfg, e[4]);
            chk("R5 xcount/xmod", {xcnt, xmod}, {e[5], e[6]});
            chk("R5 ycount/ymod", {ycnt, ymod}, {e[7], e[8]});
            chk("R7 cur_ptr", cur_ptr, {e[1], e[0]});
            chk("R7 cur_addr", cur_addr, {e[3], e[2]});
            chk("R8 cur_x", cur_x, (e[5] == 0) ? 16'hFFFF : e[5]);
            chk("R8 cur_y", cur_y, (e[7] == 0) ? 16'hFFFF : e[7]);
            chk("R9 elem_bytes", elem_bytes, eb);
            chk("R10 err on misalign", err, misal);
            chk("R11 run set", run, 1);
        end
        chk("R12 request dropped at end", rd_req, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset run/err", {run, err}, 2'b00);
        chk("R12 reset rd_req", rd_req, 0);
        // full sweep of mode code and length
        for (int fl = 0; fl < 8; fl++) begin
            for (int ns = 0; ns < 16; ns++) begin
                int idx = fl * 16 + ns;
                run_case(fl, ns, idx % 4, 32'h0001_1000 + 32'(idx * 6),
                         32'h0002_3000 + 32'(idx * 4), 32'h0000_4000 + 32'(idx),
                         16'(idx + 1), 16'(idx + 2));
            end
        end
        // R8: zero counts presented with no fetch
        run_case(0, 0, 2, 32'h10, 32'h20, 32'h100, 16'h0, 16'h0);
        // R8: large list landing a zero X count from memory
        run_case(7, 9, 0, 32'h0000_2008, 32'h40, 32'h0, 16'h5, 16'h6);
        // R10: misaligned 4-byte start address, autobuffer
        run_case(1, 0, 2, 32'h0, 32'h0, 32'h0000_0102, 16'h3, 16'h3);
        // R10: aligned 2-byte start address, stop
        run_case(0, 0, 1, 32'h0, 32'h0, 32'h0000_0102, 16'h3, 16'h3);
        // R11: start while busy is ignored (one done only)
        @(negedge clk);
        cfg_in = {1'b0, 3'd7, 4'd9, 8'h00};
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R11 still busy with start held", busy, 1);
        start = 1'b0;
        for (int c = 0; c < 300 && busy; c++) @(negedge clk);
        chk("R11 returned to idle", busy, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule